// File: doc/BRIEF.md
# Reset and power-mode controller

This block sits next to a small 8-bit microcontroller core and owns its timing, reset and sleep behaviour. Running from the oscillator clock, it produces a half-rate clock through a toggle flop, so the duty cycle of the incoming clock never matters. It also counts oscillator clocks into machine cycles of `MC_LEN` clocks and raises a one-clock strobe on the last clock of each machine cycle.

The reset pin is passed through a synchronizer. It becomes an internal reset only after it has stayed high for `QUAL_MC` full machine cycles with the oscillator running. Port outputs, by contrast, are forced high in the same cycle the pin goes high. A power-control register, written by the core, selects idle or power-down. In idle the core clock enable is removed while peripherals keep running, and any enabled pending interrupt or a reset ends it. In power-down the oscillator enable is removed as well, and only a reset ends it. When a reset ends idle, the core runs again at once, but RAM writes are blocked until the internal reset takes over. Port writes stay allowed in that window.

Top module: `pmu_clkrst`

## Requirements
- R1: `mc_strobe` is high for exactly one clock on every 12th running clock. The first pulse comes on the 11th clock edge after `por_n` is released, and the strobe is never high while `osc_en` is low.
- R2: `clk_half` starts at 0 and inverts on every clock edge while `osc_en` is high, giving a period of two oscillator clocks.
- R3: `sys_rst` rises 26 clock edges after `rst_pin` goes high (2 synchronizer stages plus 24 qualified clocks). A pin pulse held for fewer than 24 clocks never asserts `sys_rst`, and one held for 24 or more always does.
- R4: `port_force_hi` is high in the same cycle in which `rst_pin` is high, without waiting for qualification. It also stays high while `sys_rst` is high.
- R5: `sys_rst` stays high while the pin stays high, and falls 3 clock edges after `rst_pin` goes low.
- R6: `pcon_q` bit 0 shows idle and bit 1 shows power-down. Bits 7, 3 and 2 hold the written value, and bits 6..4 always read 0. Writing bit 1 enters power-down even when bit 0 is set in the same write. Reset clears the whole register to 0, and idle and power-down are never both set.
- R7: In idle, `cpu_ce` is low while `periph_ce` and `osc_en` stay high.
- R8: Idle ends at the next edge when `irq_all_en` is high and some bit of `irq_pend & irq_en` is set. Idle then clears bit 0, while bits 7, 3 and 2 are kept. Pending interrupts that are masked do not end idle.
- R9: In power-down, `osc_en`, `periph_ce` and `cpu_ce` are low, `clk_half` holds its value, no strobe occurs, and interrupts do not end the mode.
- R10: In power-down, a high `rst_pin` restarts `osc_en` 2 edges later. Power-down is left only through the qualified `sys_rst`, after which `pcon_q` reads 0.
- R11: When `rst_pin` goes high during idle, idle ends 3 edges later and `cpu_ce` returns. `ram_wr_inhibit` then stays high until `sys_rst` has taken over, and it is low outside that window.
- R12: A power-control write is ignored while `cpu_ce` is low or while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| irq_pend | input | N_IRQ | Interrupt pending flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| irq_all_en | input | 1 | Global interrupt enable |
| pcon_we | input | 1 | Power-control write strobe from the core |
| pcon_wdata | input | 8 | Power-control write data |
| pcon_q | output | 8 | Power-control register read value |
| idle_mode | output | 1 | Idle mode active |
| pd_mode | output | 1 | Power-down mode active |
| osc_en | output | 1 | Oscillator run enable |
| clk_half | output | 1 | Oscillator divided by two |
| mc_strobe | output | 1 | Last-clock-of-machine-cycle strobe |
| cpu_ce | output | 1 | Core clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| sys_rst | output | 1 | Qualified internal reset |
| port_force_hi | output | 1 | Force all port outputs to 1 |
| ram_wr_inhibit | output | 1 | Block internal RAM writes |

## Verification
A machine-cycle counter off by one shows at once as a strobe spacing other than 12 clocks. A qualification counter that counts wrongly moves the `sys_rst` edge away from clock 26, or lets a 23-clock pin pulse reset the part. A mode register in the wrong state shows within one clock on `cpu_ce`, `osc_en` or the low bits of `pcon_q`. A stale inhibit flag shows as `ram_wr_inhibit` still high once the reset has settled.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2
   } pmode_e;

   localparam int PCON_W   = 8;
   localparam int IDLE_BIT = 0;
   localparam int DOWN_BIT = 1;
   // bits that simply store what is written; 6..4 are absent and read 0
   localparam logic [PCON_W-1:0] PCON_KEEP = 8'h8C;

   function automatic int cnt_w(input int maxval);
      return (maxval <= 1) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/pmu_sync.sv
module pmu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               sr <= '0;
            end else begin
               sr[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  sr[i] <= sr[i-1];
               end
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pmu_timebase.sv
module pmu_timebase #(
   parameter int MC_LEN = 12
) (
   input  logic clk,
   input  logic por_n,
   input  logic run,
   output logic clk_half,
   output logic mc_strobe
);

   localparam int             PW   = pmu_pkg::cnt_w(MC_LEN - 1);
   localparam logic [PW-1:0]  LAST = PW'(MC_LEN - 1);
   localparam bool_pow2 = ((MC_LEN & (MC_LEN - 1)) == 0);

   logic [PW-1:0] phase_q;
   logic          half_q;
   logic          at_last;

   assign at_last = (phase_q == LAST);

   generate
      if (bool_pow2) begin : g_wrap
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)   phase_q <= '0;
            else if (run) phase_q <= phase_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)       phase_q <= '0;
            else if (run) begin
               if (at_last)   phase_q <= '0;
               else           phase_q <= phase_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)   half_q <= 1'b0;
      else if (run) half_q <= ~half_q;
   end

   assign clk_half  = half_q;
   assign mc_strobe = run & at_last;

endmodule

// File: rtl/pmu_rstqual.sv
module pmu_rstqual #(
   parameter int MC_LEN  = 12,
   parameter int QUAL_MC = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_s,
   input  logic run,
   output logic sys_rst
);

   localparam int            QUAL = QUAL_MC * MC_LEN;
   localparam int            QW   = pmu_pkg::cnt_w(QUAL);
   localparam logic [QW-1:0] QMAX = QW'(QUAL);

   logic [QW-1:0] held_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  held_q <= '0;
      else if (!pin_s)             held_q <= '0;
      else if (run && held_q != QMAX) held_q <= held_q + 1'b1;
   end

   assign sys_rst = (held_q == QMAX);

endmodule

// File: rtl/pmu_modes.sv
module pmu_modes #(
   parameter int N_IRQ = 5
) (
   input  logic                        clk,
   input  logic                        por_n,
   input  logic                        pin_s,
   input  logic                        sys_rst,
   input  logic                        run,
   input  logic [N_IRQ-1:0]            irq_pend,
   input  logic [N_IRQ-1:0]            irq_en,
   input  logic                        irq_all_en,
   input  logic                        pcon_we,
   input  logic [pmu_pkg::PCON_W-1:0]  pcon_wdata,
   output pmu_pkg::pmode_e             mode,
   output logic [pmu_pkg::PCON_W-1:0]  pcon_q,
   output logic                        cpu_ce,
   output logic                        inhibit
);
   import pmu_pkg::*;

   pmode_e             mode_q;
   logic [PCON_W-1:0]  keep_q;
   logic               inh_q;
   logic               wake;
   logic               wr_ok;

   assign cpu_ce = run & (mode_q == PM_RUN);
   assign wake   = irq_all_en & (|(irq_pend & irq_en));
   assign wr_ok  = pcon_we & cpu_ce & ~sys_rst;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q <= PM_RUN;
         keep_q <= '0;
         inh_q  <= 1'b0;
      end else if (sys_rst) begin
         mode_q <= PM_RUN;
         keep_q <= '0;
         inh_q  <= 1'b0;
      end else begin
         case (mode_q)
            PM_RUN: begin
               if (wr_ok) begin
                  if (pcon_wdata[DOWN_BIT])      mode_q <= PM_DOWN;
                  else if (pcon_wdata[IDLE_BIT]) mode_q <= PM_IDLE;
               end
            end
            PM_IDLE: begin
               if (pin_s) begin
                  mode_q <= PM_RUN;
                  inh_q  <= 1'b1;
               end else if (wake) begin
                  mode_q <= PM_RUN;
               end
            end
            PM_DOWN: mode_q <= PM_DOWN;
            default: mode_q <= PM_RUN;
         endcase
         if (wr_ok) keep_q <= pcon_wdata & PCON_KEEP;
         if (inh_q && !pin_s) inh_q <= 1'b0;
      end
   end

   always_comb begin
      pcon_q           = keep_q;
      pcon_q[IDLE_BIT] = (mode_q == PM_IDLE);
      pcon_q[DOWN_BIT] = (mode_q == PM_DOWN);
   end

   assign mode    = mode_q;
   assign inhibit = inh_q;

endmodule

// File: rtl/pmu_clkrst.sv
module pmu_clkrst #(
   parameter int MC_LEN      = 12,
   parameter int QUAL_MC     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int N_IRQ       = 5
) (
   input  logic             clk_osc,
   input  logic             por_n,
   input  logic             rst_pin,
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             irq_all_en,
   input  logic             pcon_we,
   input  logic [7:0]       pcon_wdata,
   output logic [7:0]       pcon_q,
   output logic             idle_mode,
   output logic             pd_mode,
   output logic             osc_en,
   output logic             clk_half,
   output logic             mc_strobe,
   output logic             cpu_ce,
   output logic             periph_ce,
   output logic             sys_rst,
   output logic             port_force_hi,
   output logic             ram_wr_inhibit
);
   import pmu_pkg::*;

   initial begin
      assert (MC_LEN >= 2)                          else $error("MC_LEN must be at least 2");
      assert (QUAL_MC >= 1)                         else $error("QUAL_MC must be at least 1");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 3) else $error("SYNC_STAGES must be 0..3");
      assert (N_IRQ >= 1)                           else $error("N_IRQ must be at least 1");
      assert (PCON_W == 8)                          else $error("power-control register is 8 bits");
   end

   logic   pin_s;
   logic   run;
   logic   rst_w;
   pmode_e mode;

   pmu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_osc),
      .por_n (por_n),
      .d     (rst_pin),
      .q     (pin_s)
   );

   // the oscillator restarts as soon as the pin is seen, even in power-down
   assign run = (mode != PM_DOWN) | pin_s;

   pmu_timebase #(.MC_LEN(MC_LEN)) u_tb (
      .clk       (clk_osc),
      .por_n     (por_n),
      .run       (run),
      .clk_half  (clk_half),
      .mc_strobe (mc_strobe)
   );

   pmu_rstqual #(.MC_LEN(MC_LEN), .QUAL_MC(QUAL_MC)) u_qual (
      .clk     (clk_osc),
      .por_n   (por_n),
      .pin_s   (pin_s),
      .run     (run),
      .sys_rst (rst_w)
   );

   pmu_modes #(.N_IRQ(N_IRQ)) u_modes (
      .clk        (clk_osc),
      .por_n      (por_n),
      .pin_s      (pin_s),
      .sys_rst    (rst_w),
      .run        (run),
      .irq_pend   (irq_pend),
      .irq_en     (irq_en),
      .irq_all_en (irq_all_en),
      .pcon_we    (pcon_we),
      .pcon_wdata (pcon_wdata),
      .mode       (mode),
      .pcon_q     (pcon_q),
      .cpu_ce     (cpu_ce),
      .inhibit    (ram_wr_inhibit)
   );

   assign idle_mode     = (mode == PM_IDLE);
   assign pd_mode       = (mode == PM_DOWN);
   assign osc_en        = run;
   assign periph_ce     = run;
   assign sys_rst       = rst_w;
   assign port_force_hi = rst_pin | rst_w;

endmodule

// File: rtl/pmu_clkrst_chk.sv
module pmu_clkrst_chk #(
   parameter int N_IRQ = 5
) (
   input logic             clk_osc,
   input logic             por_n,
   input logic             rst_pin,
   input logic [N_IRQ-1:0] irq_pend,
   input logic [N_IRQ-1:0] irq_en,
   input logic             irq_all_en,
   input logic [7:0]       pcon_q,
   input logic             idle_mode,
   input logic             pd_mode,
   input logic             osc_en,
   input logic             clk_half,
   input logic             mc_strobe,
   input logic             cpu_ce,
   input logic             periph_ce,
   input logic             sys_rst,
   input logic             port_force_hi,
   input logic             ram_wr_inhibit
);

   logic irq_hit;
   assign irq_hit = irq_all_en && (|(irq_pend & irq_en));

   p_strobe_gap_r1: assert property (@(posedge clk_osc) disable iff (!por_n)
      mc_strobe |=> !mc_strobe);
   p_strobe_run_r1: assert property (@(posedge clk_osc) disable iff (!por_n)
      mc_strobe |-> osc_en);
   p_half_toggle_r2: assert property (@(posedge clk_osc) disable iff (!por_n)
      osc_en |=> (clk_half != $past(clk_half)));
   p_force_pin_r4: assert property (@(posedge clk_osc) disable iff (!por_n)
      rst_pin |-> port_force_hi);
   p_force_rst_r4: assert property (@(posedge clk_osc) disable iff (!por_n)
      sys_rst |-> port_force_hi);
   p_excl_r6: assert property (@(posedge clk_osc) disable iff (!por_n)
      !(idle_mode && pd_mode));
   p_hole_r6: assert property (@(posedge clk_osc) disable iff (!por_n)
      pcon_q[6:4] == 3'b000);
   p_idle_gate_r7: assert property (@(posedge clk_osc) disable iff (!por_n)
      idle_mode |-> (!cpu_ce && periph_ce && osc_en));
   p_wake_r8: assert property (@(posedge clk_osc) disable iff (!por_n)
      (idle_mode && irq_hit) |=> !idle_mode);
   p_pd_gate_r9: assert property (@(posedge clk_osc) disable iff (!por_n)
      pd_mode |-> !cpu_ce);
   p_pd_hold_r9: assert property (@(posedge clk_osc) disable iff (!por_n)
      !osc_en |=> $stable(clk_half));
   p_pd_osc_r9: assert property (@(posedge clk_osc) disable iff (!por_n)
      (pd_mode && !rst_pin && !$past(rst_pin) && !$past(rst_pin, 2) && !$past(rst_pin, 3))
      |-> !osc_en);
   p_rst_exit_r10: assert property (@(posedge clk_osc) disable iff (!por_n)
      sys_rst |=> (!pd_mode && !idle_mode));
   p_inh_run_r11: assert property (@(posedge clk_osc) disable iff (!por_n)
      ram_wr_inhibit |-> (!idle_mode && !pd_mode));

endmodule

bind pmu_clkrst pmu_clkrst_chk #(.N_IRQ(N_IRQ)) u_chk (
   .clk_osc        (clk_osc),
   .por_n          (por_n),
   .rst_pin        (rst_pin),
   .irq_pend       (irq_pend),
   .irq_en         (irq_en),
   .irq_all_en     (irq_all_en),
   .pcon_q         (pcon_q),
   .idle_mode      (idle_mode),
   .pd_mode        (pd_mode),
   .osc_en         (osc_en),
   .clk_half       (clk_half),
   .mc_strobe      (mc_strobe),
   .cpu_ce         (cpu_ce),
   .periph_ce      (periph_ce),
   .sys_rst        (sys_rst),
   .port_force_hi  (port_force_hi),
   .ram_wr_inhibit (ram_wr_inhibit)
);

// File: tb/pmu_clkrst_test.sv
`timescale 1ns/1ps
module pmu_clkrst_test;

   localparam int NI = 5;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          rst_pin = 1'b0;
   logic [NI-1:0] irq_pend = '0;
   logic [NI-1:0] irq_en = '0;
   logic          irq_all_en = 1'b0;
   logic          pcon_we = 1'b0;
   logic [7:0]    pcon_wdata = '0;
   logic [7:0]    pcon_q;
   logic          idle_mode, pd_mode, osc_en, clk_half, mc_strobe;
   logic          cpu_ce, periph_ce, sys_rst, port_force_hi, ram_wr_inhibit;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pmu_clkrst #(.MC_LEN(12), .QUAL_MC(2), .SYNC_STAGES(2), .N_IRQ(NI)) uut (
      .clk_osc(clk), .por_n(por_n), .rst_pin(rst_pin),
      .irq_pend(irq_pend), .irq_en(irq_en), .irq_all_en(irq_all_en),
      .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .pcon_q(pcon_q),
      .idle_mode(idle_mode), .pd_mode(pd_mode), .osc_en(osc_en),
      .clk_half(clk_half), .mc_strobe(mc_strobe), .cpu_ce(cpu_ce),
      .periph_ce(periph_ce), .sys_rst(sys_rst), .port_force_hi(port_force_hi),
      .ram_wr_inhibit(ram_wr_inhibit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pcon_write(input logic [7:0] v);
      pcon_we    = 1'b1;
      pcon_wdata = v;
      step(1);
      pcon_we    = 1'b0;
   endtask

   task automatic wake_all();
      irq_pend = '1; irq_en = '1; irq_all_en = 1'b1;
      step(1);
      irq_pend = '0; irq_en = '0; irq_all_en = 1'b0;
   endtask

   task automatic full_reset();
      rst_pin = 1'b1;
      step(30);
      rst_pin = 1'b0;
      step(5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(4);
      // reset state
      chk("R6 pcon after por", pcon_q, 8'h00);
      chk("R3 sys_rst after por", sys_rst, 0);
      chk("R4 port_force idle", port_force_hi, 0);
      chk("R11 inhibit after por", ram_wr_inhibit, 0);
      chk("R7 cpu_ce after por", cpu_ce, 1);
      por_n = 1'b1;

      // R1 / R2: strobe position and half-rate clock
      for (int k = 1; k <= 48; k++) begin
         step(1);
         chk("R1 strobe position", mc_strobe, (k % 12) == 11);
         chk("R2 clk_half phase", clk_half, k % 2);
      end

      // R6: sweep of every power-control write value
      for (int v = 0; v < 256; v++) begin
         logic [7:0] exp_after;
         exp_after = (8'(v) & 8'h8C) | (v[1] ? 8'h02 : (v[0] ? 8'h01 : 8'h00));
         pcon_write(8'(v));
         chk("R6 pcon write value", pcon_q, exp_after);
         chk("R6 pd wins", pd_mode, v[1]);
         chk("R6 idle set", idle_mode, v[0] & ~v[1]);
         if (v[1]) begin
            chk("R9 pd osc off", osc_en, 0);
            chk("R9 pd periph off", periph_ce, 0);
            full_reset();
            chk("R10 pd exit by reset", pd_mode, 0);
            chk("R10 pcon cleared", pcon_q, 8'h00);
         end else if (v[0]) begin
            chk("R7 idle cpu off", cpu_ce, 0);
            chk("R7 idle periph on", {periph_ce, osc_en}, 2'b11);
            wake_all();
            chk("R8 irq wake keeps bits", pcon_q, 8'(v) & 8'h8C);
            chk("R8 idle cleared", idle_mode, 0);
         end
      end

      // R8: wake condition sweep
      for (int p = 0; p < 32; p++) begin
         for (int e = 0; e < 32; e++) begin
            for (int g = 0; g < 2; g++) begin
               bit exp_idle;
               pcon_write(8'h01);
               irq_pend = 5'(p); irq_en = 5'(e); irq_all_en = g[0];
               step(1);
               exp_idle = !((g == 1) && ((p & e) != 0));
               chk("R8 wake decision", idle_mode, exp_idle);
               irq_pend = '0; irq_en = '0; irq_all_en = 1'b0;
               if (idle_mode) wake_all();
            end
         end
      end

      // R12: write while idle is ignored
      pcon_write(8'h01);
      pcon_write(8'h02);
      chk("R12 write ignored when cpu stopped", {pd_mode, idle_mode}, 2'b01);
      wake_all();

      // R9: power-down freeze and interrupt immunity
      pcon_write(8'h02);
      begin
         logic h0;
         h0 = clk_half;
         irq_pend = '1; irq_en = '1; irq_all_en = 1'b1;
         for (int k = 0; k < 24; k++) begin
            step(1);
            chk("R9 no strobe in pd", mc_strobe, 0);
            chk("R9 clk_half held", clk_half, h0);
         end
         chk("R9 irq does not end pd", pd_mode, 1);
         irq_pend = '0; irq_en = '0; irq_all_en = 1'b0;
      end
      // R10: pin restarts oscillator two edges later
      rst_pin = 1'b1;
      #1;
      chk("R4 force at once", port_force_hi, 1);
      step(1);
      chk("R10 osc still off", osc_en, 0);
      step(1);
      chk("R10 osc restarted", osc_en, 1);
      chk("R10 still pd before qual", pd_mode, 1);
      step(28);
      chk("R10 pd left", pd_mode, 0);
      rst_pin = 1'b0;
      step(5);

      // R3 / R5 / R12 / R4: qualification latency
      pcon_write(8'h8C);
      rst_pin = 1'b1;
      step(25);
      chk("R3 not yet at edge 25", sys_rst, 0);
      step(1);
      chk("R3 asserted at edge 26", sys_rst, 1);
      pcon_write(8'h84);
      chk("R12 write ignored in reset", pcon_q, 8'h00);
      chk("R6 reset clears pcon", pcon_q, 8'h00);
      rst_pin = 1'b0;
      step(1);
      chk("R4 force held by sys_rst", port_force_hi, 1);
      step(1);
      chk("R5 still in reset", sys_rst, 1);
      step(1);
      chk("R5 released after 3 edges", sys_rst, 0);
      chk("R4 force released", port_force_hi, 0);
      step(3);

      // R3: pulse width sweep around the threshold
      for (int len = 20; len <= 27; len++) begin
         bit seen;
         seen = 1'b0;
         rst_pin = 1'b1;
         for (int k = 0; k < len; k++) begin
            step(1);
            seen |= sys_rst;
         end
         rst_pin = 1'b0;
         for (int k = 0; k < 4; k++) begin
            step(1);
            seen |= sys_rst;
         end
         chk("R3 pulse width threshold", seen, len >= 24);
         step(6);
      end

      // R11: idle ended by reset pin
      pcon_write(8'h01);
      chk("R11 inhibit low before", ram_wr_inhibit, 0);
      rst_pin = 1'b1;
      step(2);
      chk("R11 still idle after 2 edges", idle_mode, 1);
      step(1);
      chk("R11 idle left after 3 edges", idle_mode, 0);
      chk("R11 cpu runs in window", cpu_ce, 1);
      chk("R11 inhibit in window", ram_wr_inhibit, 1);
      step(10);
      chk("R11 inhibit held", ram_wr_inhibit, 1);
      chk("R11 no reset yet", sys_rst, 0);
      step(17);
      chk("R11 reset took over", sys_rst, 1);
      chk("R11 inhibit released", ram_wr_inhibit, 0);
      rst_pin = 1'b0;
      step(5);
      chk("R11 inhibit stays low", ram_wr_inhibit, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule